// File: doc/BRIEF.md
# Lane-Aligned Vector Element Search Unit

This unit takes two 128-bit operand vectors and compares them element by element, always pairing an element of A with the element of B in the same position. The element width is 8, 16 or 32 bits. A mode input chooses the event it looks for. In equal mode the event is the first pair that is identical. In not-equal mode the event is the first pair that differs. An optional terminator search can also stop the scan at the first all-zero element of A.

One start pulse launches an operation. On the following cycle a done pulse is raised. At that point the result vector holds the byte offset of whichever came first, the event or the terminator, and a 2-bit condition code classifies the outcome. In not-equal mode the condition code also reports the unsigned ordering of the two elements at the first mismatch. Both outputs hold their values until the next start.

Top module: `vfind_unit`

## Requirements
- R1: `done_o` is high in exactly the cycle after a cycle with `start_i` high. `result_o` and `cc_o` change only on that edge and otherwise keep their values.
- R2: Byte k of a vector is bits [127-8k -: 8]. An element of S bytes with number j occupies bytes j*S to j*S+S-1. An A element is compared only with the B element at the same number.
- R3: `esize_i` selects the element width: 0 gives bytes, 1 gives 16-bit elements, 2 and 3 both give 32-bit elements. The terminator test checks a whole element. The reported offset is always a multiple of the element size.
- R4: `result_o[63:0]` is the smaller of the first event byte offset and the first terminator byte offset. `result_o[127:64]` is zero. The value 16 means that neither was found.
- R5: Bit 1 of `ctrl_i` enables the terminator search. When that bit is clear, the terminator offset is taken as 16 and `cc_o` is never 0. All other `ctrl_i` bits have no effect.
- R6: In equal mode (`mode_ne_i`=0), `cc_o` takes one of four values. It is 3 when there is neither an event nor a terminator. It is 1 when there is an event and no terminator. It is 2 when the event lies strictly before the terminator. It is 0 in all other cases, including an event and a terminator in the same element.
- R7: In not-equal mode (`mode_ne_i`=1), `cc_o` is 3 when there is neither a mismatch nor a terminator. It is 0 when the terminator lies strictly before the first mismatch.
- R8: In not-equal mode, every other case yields `cc_o`=1 when the A element at the first mismatch is unsigned-less than the B element, and `cc_o`=2 otherwise. This includes a terminator in the same element as the mismatch.
- R9: While `rst_ni` is low, `done_o`, `result_o` and `cc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches one search with the current operands |
| mode_ne_i | input | 1 | 0: find first equal pair, 1: find first unequal pair |
| esize_i | input | 2 | Element width select |
| ctrl_i | input | 4 | Control field; bit 1 enables the terminator search |
| op_a_i | input | 128 | Operand A |
| op_b_i | input | 128 | Operand B |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 128 | Byte offset in the low doubleword, zero in the high doubleword |
| cc_o | output | 2 | Condition code |

## Verification
Every result is registered once, so the offset, the condition code and the done pulse are all due on the first rising edge after the edge that sampled `start_i`. The bench drives the operands and the start pulse on a falling edge and reads all three outputs on the next falling edge, half a period after they settle. It then checks on one more falling edge that done has dropped and that the offset has held. The directed cases place events and terminators at chosen offsets for each element width. These include ties in the same element and an ordering that differs between signed and unsigned comparison.

// File: rtl/vfind_pkg.sv
package vfind_pkg;
  typedef logic [1:0] cc_t;
  localparam cc_t CC_TERM = 2'd0;
  localparam cc_t CC_ONE  = 2'd1;
  localparam cc_t CC_TWO  = 2'd2;
  localparam cc_t CC_NONE = 2'd3;

  localparam int NUM_SIZES = 3;  // 1, 2, 4 byte elements

  // log2 of element bytes; the spare code maps to words
  function automatic logic [1:0] esize_log(input logic [1:0] es);
    return (es == 2'd3) ? 2'd2 : es;
  endfunction
endpackage

// File: rtl/vfind_flags.sv
// Per-element equal / unequal / zero flags, placed at each element's first byte.
module vfind_flags #(
  parameter int VEC_W = 128,
  parameter int LG    = 0
) (
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  output logic [VEC_W/8-1:0] eq_o,
  output logic [VEC_W/8-1:0] ne_o,
  output logic [VEC_W/8-1:0] zero_o
);
  localparam int EB = 1 << LG;
  localparam int EW = 8 * EB;
  localparam int NE = VEC_W / EW;

  logic [EW-1:0] a_el, b_el;

  always_comb begin
    eq_o   = '0;
    ne_o   = '0;
    zero_o = '0;
    a_el   = '0;
    b_el   = '0;
    for (int e = 0; e < NE; e++) begin
      a_el = a_i[VEC_W-1-e*EW -: EW];
      b_el = b_i[VEC_W-1-e*EW -: EW];
      eq_o[e*EB]   = (a_el == b_el);
      ne_o[e*EB]   = (a_el != b_el);
      zero_o[e*EB] = (a_el == '0);
    end
  end
endmodule

// File: rtl/vfind_prio.sv
// Lowest set bit index; N when empty.
module vfind_prio #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = IDX_W'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vfind_mag.sv
// Unsigned A<B on the element that holds byte offset idx_i.
module vfind_mag #(
  parameter int VEC_W = 128,
  parameter int IDX_W = 5
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [1:0]       lg_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             lt_o
);
  localparam int NB  = VEC_W / 8;
  localparam int PAD = 24;

  logic [IDX_W-1:0]   elem_no, base;
  logic [VEC_W+PAD-1:0] a_pad, b_pad;
  logic [31:0]        a_win, b_win, a_el, b_el;
  logic [IDX_W+2:0]   bit_off;
  logic [4:0]         rsh;

  always_comb begin
    elem_no = idx_i >> lg_i;
    base    = (idx_i >= IDX_W'(NB)) ? '0 : (elem_no << lg_i);
    bit_off = {base, 3'b000};
    a_pad   = {a_i, {PAD{1'b0}}};
    b_pad   = {b_i, {PAD{1'b0}}};
    a_win   = a_pad[VEC_W+PAD-1-bit_off -: 32];
    b_win   = b_pad[VEC_W+PAD-1-bit_off -: 32];
    unique case (lg_i)
      2'd0:    rsh = 5'd24;
      2'd1:    rsh = 5'd16;
      default: rsh = 5'd0;
    endcase
    a_el = a_win >> rsh;
    b_el = b_win >> rsh;
    lt_o = (a_el < b_el);
  end
endmodule

// File: rtl/vfind_unit.sv
module vfind_unit
  import vfind_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int CTRL_W = 4,
  parameter int ZS_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_ne_i,
  input  logic [1:0]        esize_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [VEC_W-1:0]  op_a_i,
  input  logic [VEC_W-1:0]  op_b_i,
  output logic              done_o,
  output logic [VEC_W-1:0]  result_o,
  output logic [1:0]        cc_o
);
  localparam int NB    = VEC_W / 8;
  localparam int IDX_W = $clog2(NB + 1);
  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NB);

  logic [NB-1:0] eq_f [NUM_SIZES];
  logic [NB-1:0] ne_f [NUM_SIZES];
  logic [NB-1:0] zr_f [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
    vfind_flags #(.VEC_W(VEC_W), .LG(g)) u_flags (
      .a_i   (op_a_i),
      .b_i   (op_b_i),
      .eq_o  (eq_f[g]),
      .ne_o  (ne_f[g]),
      .zero_o(zr_f[g])
    );
  end

  logic [1:0]       lg;
  logic [NB-1:0]    ev_bits, zr_bits;
  logic [IDX_W-1:0] first_ev, first_zr, idx;
  logic             a_lt;
  cc_t              cc_d;
  logic [IDX_W-1:0] align_mask;

  assign lg = esize_log(esize_i);

  always_comb begin
    ev_bits = mode_ne_i ? ne_f[lg] : eq_f[lg];
    zr_bits = ctrl_i[ZS_BIT] ? zr_f[lg] : '0;
  end

  vfind_prio #(.N(NB), .IDX_W(IDX_W)) u_prio_ev (.bits_i(ev_bits), .idx_o(first_ev));
  vfind_prio #(.N(NB), .IDX_W(IDX_W)) u_prio_zr (.bits_i(zr_bits), .idx_o(first_zr));

  vfind_mag #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_mag (
    .a_i  (op_a_i),
    .b_i  (op_b_i),
    .lg_i (lg),
    .idx_i(first_ev),
    .lt_o (a_lt)
  );

  assign idx = (first_ev < first_zr) ? first_ev : first_zr;

  always_comb begin
    if (first_ev == NONE_IDX && first_zr == NONE_IDX) begin
      cc_d = CC_NONE;
    end else if (mode_ne_i) begin
      if (first_zr < first_ev) cc_d = CC_TERM;
      else                     cc_d = a_lt ? CC_ONE : CC_TWO;
    end else begin
      if (first_zr == NONE_IDX)     cc_d = CC_ONE;
      else if (first_ev < first_zr) cc_d = CC_TWO;
      else                          cc_d = CC_TERM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
      cc_o     <= CC_TERM;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o <= {{(VEC_W-IDX_W){1'b0}}, idx};
        cc_o     <= cc_d;
      end
    end
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i[CTRL_W-1:ZS_BIT+1], ctrl_i[ZS_BIT-1:0]};

  // element alignment mask for the offset check
  assign align_mask = IDX_W'((1 << lg) - 1);

  p_done_after_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  p_no_spurious_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  p_hold_outputs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(cc_o)));
  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o[63:0] <= 64'(NB)));
  p_idx_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((result_o[IDX_W-1:0] & $past(align_mask)) == '0));
  p_none_means_16_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o == CC_NONE) |-> (result_o[63:0] == 64'(NB)));
  p_no_term_cc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ctrl_i[ZS_BIT]) |=> (cc_o != CC_TERM));
endmodule

// File: tb/vfind_unit_tb_top.sv
module vfind_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode_ne = 1'b0;
  logic [1:0]   esize = 2'd0;
  logic [3:0]   ctrl = 4'd0;
  logic [127:0] op_a = '0, op_b = '0;
  logic         done;
  logic [127:0] result;
  logic [1:0]   cc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vfind_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_ne_i(mode_ne),
    .esize_i(esize), .ctrl_i(ctrl), .op_a_i(op_a), .op_b_i(op_b),
    .done_o(done), .result_o(result), .cc_o(cc)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic ne, input logic [1:0] es,
                        input logic [3:0] c, input logic [127:0] a, input logic [127:0] b,
                        input int exp_idx, input int exp_cc);
    @(negedge clk);
    mode_ne = ne; esize = es; ctrl = c; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({"R1 done ", tag}, 128'(done), 128'd1);
    chk({"R4 index ", tag}, 128'(result[63:0]), 128'(exp_idx));
    chk({"R4 high zero ", tag}, 128'(result[127:64]), 128'd0);
    chk({"cc ", tag}, 128'(cc), 128'(exp_cc));
    op_a = ~a; op_b = b;
    @(negedge clk);
    chk({"R1 done drop ", tag}, 128'(done), 128'd0);
    chk({"R1 hold ", tag}, 128'(result[63:0]), 128'(exp_idx));
  endtask

  task automatic t_reset;
    chk("R9 done", 128'(done), 128'd0);
    chk("R9 result", result, 128'd0);
    chk("R9 cc", 128'(cc), 128'd0);
  endtask

  task automatic t_eq_bytes;
    run_op("R6 R2 eq8 no-zs", 1'b0, 2'd0, 4'b0000,
      128'h00112233_44556677_8899AABB_CCDDEEFF,
      128'hFFEEDDCC_BB559988_77665544_33221100, 5, 1);
    run_op("R5 R6 eq8 zs", 1'b0, 2'd0, 4'b0010,
      128'h00112233_44556677_8899AABB_CCDDEEFF,
      128'hFFEEDDCC_BB559988_77665544_33221100, 0, 0);
    run_op("R6 eq8 hit before zero", 1'b0, 2'd0, 4'b0010,
      128'hAABBCC00_11111111_11111111_11111111,
      128'h55BB5555_55555555_55555555_55555555, 1, 2);
    run_op("R6 eq8 none", 1'b0, 2'd0, 4'b0010,
      {16{8'h11}}, {16{8'h22}}, 16, 3);
    run_op("R6 eq8 tie same element", 1'b0, 2'd0, 4'b0010,
      128'h11110011_11111111_11111111_11111111,
      128'h22220022_22222222_22222222_22222222, 2, 0);
  endtask

  task automatic t_eq_wide;
    run_op("R3 eq16 zero test whole element", 1'b0, 2'd1, 4'b0010,
      128'h0001_0002_0003_0004_0005_0006_0007_0008,
      128'h1001_1002_1003_0004_1005_1006_1007_1008, 6, 1);
    run_op("R3 same data as bytes", 1'b0, 2'd0, 4'b0010,
      128'h0001_0002_0003_0004_0005_0006_0007_0008,
      128'h1001_1002_1003_0004_1005_1006_1007_1008, 0, 0);
    run_op("R3 eq32", 1'b0, 2'd2, 4'b0010,
      128'h11111111_22222222_33333333_44444444,
      128'h11111110_22222222_33333333_44444444, 4, 1);
    run_op("R3 esize code 3 as words", 1'b0, 2'd3, 4'b0010,
      128'h11111111_22222222_33333333_44444444,
      128'h11111110_22222222_33333333_44444444, 4, 1);
  endtask

  task automatic t_ne;
    run_op("R7 ne8 none", 1'b1, 2'd0, 4'b0010, {16{8'h33}}, {16{8'h33}}, 16, 3);
    run_op("R8 ne8 a<b", 1'b1, 2'd0, 4'b0010,
      128'h33333333_33333333_33403333_33333333,
      128'h33333333_33333333_33803333_33333333, 9, 1);
    run_op("R8 ne8 a>b", 1'b1, 2'd0, 4'b0010,
      128'h33333333_33333333_33803333_33333333,
      128'h33333333_33333333_33403333_33333333, 9, 2);
    run_op("R7 ne8 zero first", 1'b1, 2'd0, 4'b0010,
      128'h33003333_33903333_33333333_33333333,
      128'h33003333_33103333_33333333_33333333, 1, 0);
    run_op("R5 R8 ne8 zs off", 1'b1, 2'd0, 4'b0000,
      128'h33003333_33903333_33333333_33333333,
      128'h33003333_33103333_33333333_33333333, 5, 2);
    run_op("R8 ne8 zero at mismatch", 1'b1, 2'd0, 4'b0010,
      128'h44444400_44444444_44444444_44444444,
      128'h44444407_44444444_44444444_44444444, 3, 1);
  endtask

  task automatic t_ne_unsigned;
    run_op("R8 ne32 unsigned", 1'b1, 2'd2, 4'b0010,
      128'h01020304_05060708_80000000_0A0B0C0D,
      128'h01020304_05060708_7FFFFFFF_0A0B0C0D, 8, 2);
    run_op("R8 R2 ne16 element compare", 1'b1, 2'd1, 4'b0010,
      128'h11111111_12345555_55555555_55555555,
      128'h11111111_12995555_55555555_55555555, 4, 1);
    run_op("R8 R2 ne8 same data", 1'b1, 2'd0, 4'b0010,
      128'h11111111_12345555_55555555_55555555,
      128'h11111111_12995555_55555555_55555555, 5, 1);
  endtask

  task automatic t_ctrl_ignored;
    run_op("R5 other ctrl bits, zs clear", 1'b0, 2'd0, 4'b1101,
      128'h00112233_44556677_8899AABB_CCDDEEFF,
      128'hFFEEDDCC_BB559988_77665544_33221100, 5, 1);
    run_op("R5 other ctrl bits, zs set", 1'b0, 2'd0, 4'b1111,
      128'h00112233_44556677_8899AABB_CCDDEEFF,
      128'hFFEEDDCC_BB559988_77665544_33221100, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_eq_bytes();
    t_eq_wide();
    t_ne();
    t_ne_unsigned();
    t_ctrl_ignored();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule